// File: doc/BRIEF.md
# Ternary Scan-Cell Compatibility Checker

This block judges whether two or three scan cells can share one level of a scan tree. It takes their test-cube bits as a stream, one test vector per beat. Each bit is ternary: 0, 1 or don't-care. At the end of the test set it reports four verdicts about cells A, B and C:
- A and B are equal-compatible.
- A and B are complement-compatible.
- C can be produced as A XOR B.
- C can be produced as A XOR NOT B.

A verdict holds only if no vector in the set breaks it. A vector in which an operand of the relation is don't-care cannot break it.

The block also works on each vector as it arrives. It merges A and B into one representative bit, where a polarity input says whether B sits behind an inverter. It also raises a strobe when exactly one of the three bits is specified. In that case the XOR relations cannot fix the two don't-care bits. They can only force those bits to be equal or opposite, and the block reports which one applies under each relation.

A start pulse rearms the verdicts. The beat that carries the last flag ends the set, and a done pulse follows it.

Top module: `tern_compat_check`

## Requirements
- R1: Ternary encoding on every bit port is 2'b00 for 0, 2'b01 for 1, and 2'b1? for don't-care. After a synchronous reset, `done`, `rep_valid` and `part_stb` are 0, and all four verdicts are 1.
- R2: `eq_ok` is cleared by any accepted beat where A and B are both specified and differ.
- R3: `inv_ok` is cleared by any accepted beat where A and B are both specified and equal.
- R4: `xor_ok` is cleared by any accepted beat where A, B and C are all specified and A^B != C.
- R5: `xnor_ok` is cleared by any accepted beat where A, B and C are all specified and A^~B != C.
- R6: A cleared verdict stays cleared until `start`. `start` sets all four verdicts to 1. When `start` and a beat arrive in the same cycle, that beat is judged against the freshly set verdicts.
- R7: `done` is high for exactly the one cycle after a beat with `in_last`. In that cycle the verdicts include the last beat.
- R8: One cycle after each beat, `rep_valid` is 1 and `rep_val` shows the merged value:
  - A if A is specified;
  - otherwise B XOR `pol_b` if B is specified;
  - otherwise don't-care, emitted as 2'b10.
- R9: One cycle after a beat with exactly one specified bit v among A, B and C, `part_stb` is 1. In that cycle `part_opp_xor` is v and `part_opp_xnor` is NOT v; a value of 1 means the two don't-care bits must be opposite. Otherwise `part_stb`, `part_opp_xor` and `part_opp_xnor` are all 0.
- R10: Cycles with `in_valid` low change no verdict and raise neither `done` nor `rep_valid`, whatever the data pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Rearm all verdicts |
| in_valid | input | 1 | Beat carries a vector |
| in_last | input | 1 | Beat is the final vector of the set |
| in_a | input | 2 | Ternary bit of cell A |
| in_b | input | 2 | Ternary bit of cell B |
| in_c | input | 2 | Ternary bit of cell C |
| pol_b | input | 1 | B is fed through an inverter in the merge |
| done | output | 1 | End-of-set pulse |
| eq_ok | output | 1 | A, B equal-compatible |
| inv_ok | output | 1 | A, B complement-compatible |
| xor_ok | output | 1 | C = A XOR B compatible |
| xnor_ok | output | 1 | C = A XOR NOT B compatible |
| rep_valid | output | 1 | Per-vector outputs are valid |
| rep_val | output | 2 | Merged ternary representative of A and B |
| part_stb | output | 1 | Vector has exactly one specified bit |
| part_opp_xor | output | 1 | Free bits must be opposite under XOR |
| part_opp_xnor | output | 1 | Free bits must be opposite under XOR-NOT |

## Verification
Every result is due in the cycle after the beat that causes it: the merged value and the partial strobe, the cleared verdicts, and the done pulse each sit behind one register stage. The bench drives each beat on a falling edge and samples one falling edge later, so every check lands on the first cycle the result is due. All 27 triples are swept under both polarities as one-beat sets with start on the same beat. Random multi-beat sets follow, with the verdicts compared only when done is high. Idle cycles carrying conflicting data are checked to leave the verdicts in place.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    localparam int TW    = 2;
    localparam int NCELL = 3;
    localparam int CW    = $clog2(NCELL + 1);

    typedef logic [TW-1:0] tern_t;

    localparam tern_t T_ZERO = 2'b00;
    localparam tern_t T_ONE  = 2'b01;
    localparam tern_t T_X    = 2'b10;

    typedef struct packed {
        logic eq;
        logic inv;
        logic xr;
        logic xn;
    } rel_t;

    localparam rel_t REL_ALL = '{eq: 1'b1, inv: 1'b1, xr: 1'b1, xn: 1'b1};

    typedef struct packed {
        logic stb;
        logic opp_xor;
        logic opp_xnor;
    } part_t;

    function automatic logic t_free(tern_t t);
        return t[1];
    endfunction

    function automatic logic t_bit(tern_t t);
        return t[0];
    endfunction

    function automatic tern_t t_make(logic v);
        return {1'b0, v};
    endfunction
endpackage

// File: rtl/tcc_rel_eval.sv
module tcc_rel_eval
    import tcc_pkg::*;
(
    input  tern_t a,
    input  tern_t b,
    input  tern_t c,
    output rel_t  ok
);
    logic pair_free;
    logic trio_free;

    always_comb begin
        pair_free = t_free(a) | t_free(b);
        trio_free = pair_free | t_free(c);
        ok.eq  = pair_free | (t_bit(a) == t_bit(b));
        ok.inv = pair_free | (t_bit(a) != t_bit(b));
        ok.xr  = trio_free | ((t_bit(a) ^ t_bit(b)) == t_bit(c));
        ok.xn  = trio_free | ((t_bit(a) ^ ~t_bit(b)) == t_bit(c));
    end
endmodule

// File: rtl/tcc_merge.sv
module tcc_merge
    import tcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  logic  pol_b,
    input  tern_t cells [NCELL],
    output logic  rep_vld,
    output tern_t rep,
    output part_t part
);
    logic [NCELL-1:0] spec;
    logic [CW-1:0]    spec_cnt;
    logic             spec_val;
    tern_t            rep_nxt;
    part_t            part_nxt;

    for (genvar i = 0; i < NCELL; i++) begin : g_spec
        assign spec[i] = ~t_free(cells[i]);
    end

    always_comb begin
        spec_cnt = '0;
        spec_val = 1'b0;
        for (int i = 0; i < NCELL; i++) begin
            spec_cnt = spec_cnt + CW'(spec[i]);
            spec_val = spec_val | (spec[i] & t_bit(cells[i]));
        end
        if (spec[0])
            rep_nxt = t_make(t_bit(cells[0]));
        else if (spec[1])
            rep_nxt = t_make(t_bit(cells[1]) ^ pol_b);
        else
            rep_nxt = T_X;
        part_nxt = '0;
        if (spec_cnt == CW'(1)) begin
            part_nxt.stb      = 1'b1;
            part_nxt.opp_xor  = spec_val;
            part_nxt.opp_xnor = ~spec_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_vld <= 1'b0;
            rep     <= T_X;
            part    <= '0;
        end else begin
            rep_vld <= valid;
            if (valid) begin
                rep  <= rep_nxt;
                part <= part_nxt;
            end else begin
                part <= '0;
            end
        end
    end
endmodule

// File: rtl/tcc_flags.sv
module tcc_flags
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic valid,
    input  logic last,
    input  rel_t ok,
    output rel_t flags,
    output logic done
);
    rel_t base;

    always_comb base = start ? REL_ALL : flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= REL_ALL;
            done  <= 1'b0;
        end else begin
            flags <= valid ? (base & ok) : base;
            done  <= valid & last;
        end
    end
endmodule

// File: rtl/tern_compat_check.sv
module tern_compat_check
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic [1:0] in_a,
    input  logic [1:0] in_b,
    input  logic [1:0] in_c,
    input  logic       pol_b,
    output logic       done,
    output logic       eq_ok,
    output logic       inv_ok,
    output logic       xor_ok,
    output logic       xnor_ok,
    output logic       rep_valid,
    output logic [1:0] rep_val,
    output logic       part_stb,
    output logic       part_opp_xor,
    output logic       part_opp_xnor
);
    tern_t cells [NCELL];
    rel_t  ok;
    rel_t  flags;
    tern_t rep;
    part_t part;

    assign cells[0] = in_a;
    assign cells[1] = in_b;
    assign cells[2] = in_c;

    tcc_rel_eval u_rel (
        .a  (cells[0]),
        .b  (cells[1]),
        .c  (cells[2]),
        .ok (ok)
    );

    tcc_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .valid (in_valid),
        .last  (in_last),
        .ok    (ok),
        .flags (flags),
        .done  (done)
    );

    tcc_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .valid   (in_valid),
        .pol_b   (pol_b),
        .cells   (cells),
        .rep_vld (rep_valid),
        .rep     (rep),
        .part    (part)
    );

    assign eq_ok         = flags.eq;
    assign inv_ok        = flags.inv;
    assign xor_ok        = flags.xr;
    assign xnor_ok       = flags.xn;
    assign rep_val       = rep;
    assign part_stb      = part.stb;
    assign part_opp_xor  = part.opp_xor;
    assign part_opp_xnor = part.opp_xnor;
endmodule

// File: rtl/tern_compat_check_sva.sv
module tern_compat_check_sva (
    input logic clk,
    input logic rst,
    input logic start,
    input logic in_valid,
    input logic in_last,
    input logic done,
    input logic eq_ok,
    input logic inv_ok,
    input logic xor_ok,
    input logic xnor_ok,
    input logic rep_valid,
    input logic part_stb,
    input logic part_opp_xor,
    input logic part_opp_xnor
);
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> done);

    p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_last));

    p_eq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (!eq_ok && !start) |=> !eq_ok);

    p_inv_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (!inv_ok && !start) |=> !inv_ok);

    p_xor_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (!xor_ok && !start) |=> !xor_ok);

    p_xnor_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (!xnor_ok && !start) |=> !xnor_ok);

    p_rearm_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !in_valid) |=> (eq_ok && inv_ok && xor_ok && xnor_ok));

    p_rep_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> rep_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !start) |=> (!rep_valid && !done
            && $stable(eq_ok) && $stable(inv_ok) && $stable(xor_ok) && $stable(xnor_ok)));

    p_part_pair_r9: assert property (@(posedge clk) disable iff (rst)
        part_stb |-> (rep_valid && (part_opp_xor != part_opp_xnor)));

    p_part_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !part_stb |-> (!part_opp_xor && !part_opp_xnor));
endmodule

bind tern_compat_check tern_compat_check_sva u_sva (.*);

// File: tb/tern_compat_check_test.sv
module tern_compat_check_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic [1:0] in_a = 2'b10;
    logic [1:0] in_b = 2'b10;
    logic [1:0] in_c = 2'b10;
    logic       pol_b = 1'b0;
    logic       done, eq_ok, inv_ok, xor_ok, xnor_ok;
    logic       rep_valid, part_stb, part_opp_xor, part_opp_xnor;
    logic [1:0] rep_val;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    tern_compat_check uut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_last(in_last),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .pol_b(pol_b),
        .done(done), .eq_ok(eq_ok), .inv_ok(inv_ok), .xor_ok(xor_ok), .xnor_ok(xnor_ok),
        .rep_valid(rep_valid), .rep_val(rep_val), .part_stb(part_stb),
        .part_opp_xor(part_opp_xor), .part_opp_xnor(part_opp_xnor)
    );

    task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic is_x(logic [1:0] t);
        return t[1];
    endfunction

    function automatic logic [3:0] ref_rel(logic [1:0] a, logic [1:0] b, logic [1:0] c);
        logic e, n, x, xn;
        e  = (is_x(a) || is_x(b)) ? 1'b1 : (a[0] == b[0]);
        n  = (is_x(a) || is_x(b)) ? 1'b1 : (a[0] != b[0]);
        x  = (is_x(a) || is_x(b) || is_x(c)) ? 1'b1 : ((a[0] ^ b[0]) == c[0]);
        xn = (is_x(a) || is_x(b) || is_x(c)) ? 1'b1 : ((a[0] ^ !b[0]) == c[0]);
        return {e, n, x, xn};
    endfunction

    function automatic logic [1:0] ref_rep(logic [1:0] a, logic [1:0] b, logic p);
        if (!is_x(a)) return {1'b0, a[0]};
        if (!is_x(b)) return {1'b0, b[0] ^ p};
        return 2'b10;
    endfunction

    function automatic logic [2:0] ref_part(logic [1:0] a, logic [1:0] b, logic [1:0] c);
        int k;
        logic v;
        k = 0;
        v = 1'b0;
        if (!is_x(a)) begin k++; v = a[0]; end
        if (!is_x(b)) begin k++; v = b[0]; end
        if (!is_x(c)) begin k++; v = c[0]; end
        if (k == 1) return {1'b1, v, !v};
        return 3'b000;
    endfunction

    function automatic logic [1:0] tern_of(int code);
        case (code)
            0: return 2'b00;
            1: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [3:0] flags_now();
        return {eq_ok, inv_ok, xor_ok, xnor_ok};
    endfunction

    // Drive one beat on a falling edge; results are checked one falling edge later.
    task automatic beat(logic [1:0] a, logic [1:0] b, logic [1:0] c, logic lst, logic st,
                        inout logic [3:0] acc);
        in_a = a; in_b = b; in_c = c;
        in_valid = 1'b1; in_last = lst; start = st;
        if (st) acc = 4'b1111;
        acc = acc & ref_rel(a, b, c);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
        check("R8", "rep_valid", {3'b0, rep_valid}, 4'b0001);
        check("R8", "rep_val", {2'b0, rep_val}, {2'b0, ref_rep(a, b, pol_b)});
        check("R9", "partial", {1'b0, part_stb, part_opp_xor, part_opp_xnor},
              {1'b0, ref_part(a, b, c)});
        check("R7", "done", {3'b0, done}, {3'b0, lst});
        if (lst) check("R2 R3 R4 R5", "verdicts at done", flags_now(), acc);
    endtask

    function automatic logic [1:0] rnd_tern();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[1:0] == 2'b11 ? 2'b11 : (lfsr[1] ? 2'b10 : {1'b0, lfsr[0]});
    endfunction

    initial begin
        logic [3:0] acc;
        acc = 4'b1111;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "verdicts after reset", flags_now(), 4'b1111);
        check("R1", "done/rep_valid/part_stb after reset", {1'b0, done, rep_valid, part_stb}, 4'b0000);

        // Exhaustive sweep: one-beat sets, start on the same beat (R6), both polarities
        for (int p = 0; p < 2; p++) begin
            pol_b = p[0];
            for (int ia = 0; ia < 3; ia++)
                for (int ib = 0; ib < 3; ib++)
                    for (int ic = 0; ic < 3; ic++)
                        beat(tern_of(ia), tern_of(ib), tern_of(ic), 1'b1, 1'b1, acc);
        end

        // R1: the alternate don't-care code 2'b11 is treated as don't-care
        pol_b = 1'b1;
        beat(2'b11, 2'b01, 2'b11, 1'b1, 1'b1, acc);

        // R6: a conflict clears eq_ok and it stays cleared across later agreeing beats
        pol_b = 1'b0;
        beat(2'b00, 2'b01, 2'b10, 1'b0, 1'b1, acc);
        beat(2'b01, 2'b01, 2'b00, 1'b0, 1'b0, acc);
        beat(2'b00, 2'b00, 2'b00, 1'b1, 1'b0, acc);
        check("R6", "eq_ok sticky", {3'b0, eq_ok}, 4'b0000);

        // R10: idle cycles with conflicting data change nothing
        in_a = 2'b00; in_b = 2'b01; in_c = 2'b00;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10", "verdicts during idle", flags_now(), acc);
            check("R10", "done/rep_valid idle", {2'b0, done, rep_valid}, 4'b0000);
        end

        // R6: separate start pulse rearms all verdicts
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6", "rearm by start", flags_now(), 4'b1111);

        // Random multi-beat sets
        for (int s = 0; s < 300; s++) begin
            int len;
            len = 1 + (s % 6);
            pol_b = s[1];
            for (int k = 0; k < len; k++) begin
                logic [1:0] a, b, c;
                a = rnd_tern(); b = rnd_tern(); c = rnd_tern();
                beat(a, b, c, k == len - 1, k == 0, acc);
            end
            if (s % 7 == 0) begin
                @(negedge clk);
                check("R7", "done lasts one cycle", {3'b0, done}, 4'b0000);
            end
        end

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule